// File: doc/BRIEF.md
# Edge-Interrupt General-Purpose I/O Port

This block is a parameterised general-purpose I/O port (eight pins by default) with a small register interface. Software sets, per pin, the output enable, the driven value and the pin's owner: either the port's own output register or a peripheral output. It reads the synchronised pin levels back through a read-only register. The output enable follows the direction register whatever the owner of the pin.

Each pin also has an edge detector with a programmable polarity. A detected edge sets a sticky per-pin flag that only a software write can clear. Software can also set flags directly. The flags, masked by per-pin enables and by a global enable input, are ORed into one interrupt request for the whole port, and software reads the flag register to find the source. The polarity is applied to the raw pin before detection. Flipping the polarity while a pin is held low therefore counts as an edge. Driving a pin through the output path, when the pad loops it back, can also raise a flag.

In the default variant, an asynchronous catch cell captures each edge from the pin itself, with no clock running. A separate wake output rises at once, so a system with every clock stopped can be woken by a pin. A synchronous-only variant can be chosen by parameter.

Top module: `gpio_edge_port`

## Requirements
- R1: The output enable of each pin (`pin_oe`) equals that pin's bit in the direction register (address 2, 1 = output), independent of the select register.
- R2: `pin_out` bit i equals `periph_out[i]` when select bit i (address 3) is 1, and equals output register bit i (address 1) when it is 0.
- R3: The output (1), direction (2), select (3), enable (4) and polarity (5) registers read back the last value written. A write to the level register (address 0) has no effect on it.
- R4: The level register (address 0) and `periph_in` show `pin_in` after `SYNC_STAGES` clock edges of synchronisation.
- R5: With polarity bit 0, a low-to-high transition on a pin sets its flag (address 6), and a high-to-low transition does not.
- R6: With polarity bit 1, a high-to-low transition sets the flag, and a low-to-high transition does not.
- R7: A write to the flag register loads it: a 1 sets a flag and a 0 clears it. Without a write, a set flag stays set.
- R8: When a detected edge and a write to the flag register fall in the same cycle, the flag of that pin ends up set, whatever value was written.
- R9: `irq` is 1 exactly when `gie` is 1 and at least one pin has both its flag and its enable bit set.
- R10: A change of the polarity bit that turns a low-to-high condition of (pin XOR polarity), or an output write that moves a looped-back pin across the selected edge, sets the flag.
- R11: With the clock stopped, an enabled edge drives `wake` high at once, while `gie` is 1.
- R12: After reset, all registers read 0, and `irq`, `wake` and `pin_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and synchroniser clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 3 | Register address (0 level, 1 output, 2 direction, 3 select, 4 enable, 5 polarity, 6 flags) |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data of the register at `bus_addr` (combinational) |
| gie | input | 1 | Global interrupt enable |
| pin_in | input | WIDTH | Raw pad levels |
| pin_out | output | WIDTH | Pad output values |
| pin_oe | output | WIDTH | Pad output enables |
| periph_out | input | WIDTH | Peripheral output values for pins given to the peripheral |
| periph_in | output | WIDTH | Synchronised pin levels for the peripheral |
| irq | output | 1 | Shared port interrupt request |
| wake | output | 1 | Clock-free wake request from enabled pending edges |

## Verification
The assertions take for granted that each pin level is held for longer than `SYNC_STAGES`+1 clock cycles between transitions. The catch cell records edges by toggle parity, so two edges inside one synchroniser window would cancel. They also assume that bus inputs change only away from the rising clock edge. The stimulus changes pins and bus signals on falling edges and waits several cycles after every pin change or polarity write before it reads or acts again. It never changes a pin and the polarity in the same step. The one exception is the directed same-cycle case, which deliberately lines a clearing write up with the cycle in which the edge arrives.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   // Register addresses; the bench and checker decode the same values.
   typedef enum logic [2:0] {
      REG_LEVEL = 3'd0,
      REG_DRIVE = 3'd1,
      REG_DIR   = 3'd2,
      REG_SEL   = 3'd3,
      REG_IEN   = 3'd4,
      REG_POL   = 3'd5,
      REG_FLAG  = 3'd6,
      REG_NONE  = 3'd7
   } gpio_reg_e;

   localparam int unsigned ADDR_W = 3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          ASYNC_CATCH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_raw,
   input  logic pol,
   output logic hw_set,
   output logic pending
);

   // Polarity folded in before detection: a rise of trig is the chosen edge.
   logic trig;
   assign trig = pin_raw ^ pol;

   generate
      if (ASYNC_CATCH) begin : g_async
         logic                   tog;
         logic [SYNC_STAGES-1:0] tsy;
         logic                   seen;

         // Clocked by the pin itself, so it records edges without clk.
         always_ff @(posedge trig or negedge rst_n) begin
            if (!rst_n) begin
               tog <= 1'b0;
            end else begin
               tog <= ~tog;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tsy  <= '0;
               seen <= 1'b0;
            end else begin
               tsy  <= {tsy[SYNC_STAGES-2:0], tog};
               seen <= tsy[SYNC_STAGES-1];
            end
         end

         assign hw_set  = tsy[SYNC_STAGES-1] ^ seen;
         assign pending = tog ^ seen;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] psy;
         logic                   t_now;
         logic                   t_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               psy <= '0;
               t_q <= 1'b0;
            end else begin
               psy <= {psy[SYNC_STAGES-2:0], pin_raw};
               t_q <= t_now;
            end
         end

         assign t_now   = psy[SYNC_STAGES-1] ^ pol;
         assign hw_set  = t_now & ~t_q;
         assign pending = hw_set;
      end
   endgenerate

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_edge_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [WIDTH-1:0]  level,
   input  logic [WIDTH-1:0]  hw_set,
   output logic [WIDTH-1:0]  rdata,
   output logic [WIDTH-1:0]  drive_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  sel_q,
   output logic [WIDTH-1:0]  ien_q,
   output logic [WIDTH-1:0]  pol_q,
   output logic [WIDTH-1:0]  flag_q
);

   gpio_reg_e  sel_reg;
   logic [WIDTH-1:0] flag_base;

   assign sel_reg = gpio_reg_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= '0;
         dir_q   <= '0;
         sel_q   <= '0;
         ien_q   <= '0;
         pol_q   <= '0;
      end else if (wr) begin
         case (sel_reg)
            REG_DRIVE: drive_q <= wdata;
            REG_DIR:   dir_q   <= wdata;
            REG_SEL:   sel_q   <= wdata;
            REG_IEN:   ien_q   <= wdata;
            REG_POL:   pol_q   <= wdata;
            default:   ;
         endcase
      end
   end

   // Software load first, hardware edges ORed last so they win a tie.
   assign flag_base = (wr && sel_reg == REG_FLAG) ? wdata : flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else begin
         flag_q <= flag_base | hw_set;
      end
   end

   always_comb begin
      case (sel_reg)
         REG_LEVEL: rdata = level;
         REG_DRIVE: rdata = drive_q;
         REG_DIR:   rdata = dir_q;
         REG_SEL:   rdata = sel_q;
         REG_IEN:   rdata = ien_q;
         REG_POL:   rdata = pol_q;
         REG_FLAG:  rdata = flag_q;
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_edge_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          ASYNC_CATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic              gie,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   input  logic [WIDTH-1:0]  periph_out,
   output logic [WIDTH-1:0]  periph_in,
   output logic              irq,
   output logic              wake
);

   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("gpio_edge_port: WIDTH must be 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_edge_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] level;
   logic [WIDTH-1:0] drive_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] sel_q;
   logic [WIDTH-1:0] ien_q;
   logic [WIDTH-1:0] pol_q;
   logic [WIDTH-1:0] flag_q;
   logic [WIDTH-1:0] hw_set;
   logic [WIDTH-1:0] pending;

   gpio_sync #(
      .WIDTH  (WIDTH),
      .STAGES (SYNC_STAGES)
   ) u_level_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (level)
   );

   for (genvar gi = 0; gi < WIDTH; gi++) begin : g_pin
      gpio_edge_cell #(
         .SYNC_STAGES (SYNC_STAGES),
         .ASYNC_CATCH (ASYNC_CATCH)
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_raw (pin_in[gi]),
         .pol     (pol_q[gi]),
         .hw_set  (hw_set[gi]),
         .pending (pending[gi])
      );

      assign pin_out[gi] = sel_q[gi] ? periph_out[gi] : drive_q[gi];
   end

   gpio_regs #(
      .WIDTH (WIDTH)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .level   (level),
      .hw_set  (hw_set),
      .rdata   (bus_rdata),
      .drive_q (drive_q),
      .dir_q   (dir_q),
      .sel_q   (sel_q),
      .ien_q   (ien_q),
      .pol_q   (pol_q),
      .flag_q  (flag_q)
   );

   assign pin_oe    = dir_q;
   assign periph_in = level;
   assign irq       = gie & (|(flag_q & ien_q));
   assign wake      = irq | (gie & (|(pending & ien_q)));

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
   import gpio_edge_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic              gie,
   input logic [WIDTH-1:0]  pin_oe,
   input logic              irq,
   input logic [WIDTH-1:0]  flag_q,
   input logic [WIDTH-1:0]  ien_q,
   input logic [WIDTH-1:0]  hw_set
);

   logic wr_dir;
   logic wr_flag;
   assign wr_dir  = bus_wr && (bus_addr == REG_DIR);
   assign wr_flag = bus_wr && (bus_addr == REG_FLAG);

   a_r1_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (pin_oe == $past(bus_wdata)));

   a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   a_r8_edge_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_flag |=> (flag_q == ($past(bus_wdata) | $past(hw_set))));

   a_r9_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq);

   a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|(flag_q & ien_q)));

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .gie       (gie),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .flag_q    (flag_q),
   .ien_q     (ien_q),
   .hw_set    (hw_set)
);

// File: tb/tb_gpio_edge_port.sv
`timescale 1ns/1ps
module tb_gpio_edge_port;

   localparam int W    = 8;
   localparam int SYNC = 2;
   localparam logic [2:0] A_LVL = 3'd0, A_DRV = 3'd1, A_DIR = 3'd2,
                          A_SEL = 3'd3, A_IEN = 3'd4, A_POL = 3'd5, A_FLG = 3'd6;

   logic         clk = 1'b0;
   logic         clk_run = 1'b1;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic [2:0]   bus_addr = 3'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         gie = 1'b0;
   logic [W-1:0] pin_in;
   logic [W-1:0] pin_out;
   logic [W-1:0] pin_oe;
   logic [W-1:0] periph_out = '0;
   logic [W-1:0] periph_in;
   logic         irq;
   logic         wake;
   logic [W-1:0] ext = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Pad model: driven pins loop back, the rest follow the external level.
   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

   always begin
      #10;
      if (clk_run) clk = ~clk;
   end

   gpio_edge_port #(.WIDTH(W), .SYNC_STAGES(SYNC)) dut (
      .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .gie,
      .pin_in, .pin_out, .pin_oe, .periph_out, .periph_in, .irq, .wake
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (SYNC + 3) @(negedge clk);
   endtask

   function automatic logic [W-1:0] new_edges(input logic [W-1:0] t_old, input logic [W-1:0] t_new);
      return t_new & ~t_old;
   endfunction

   function automatic logic exp_irq(input logic g, input logic [W-1:0] f, input logic [W-1:0] e);
      return g & (|(f & e));
   endfunction

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #4000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung expected finish");
         report();
         $finish;
      end
   end

   initial begin
      logic [W-1:0] r;
      logic [W-1:0] pol_m;
      logic [W-1:0] flag_m;
      logic [W-1:0] ien_m;
      logic [W-1:0] t_old;
      void'($urandom(32'h1234_abcd));
      pol_m  = '0;
      flag_m = '0;
      ien_m  = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      for (int a = 0; a < 7; a++) begin
         rd(3'(a), r);
         check("R12 reset register", r, 0);
      end
      check("R12 reset irq", irq, 0);
      check("R12 reset wake", wake, 0);
      check("R12 reset oe", pin_oe, 0);

      // R1, R2, R3 direction, mux and readback
      for (int i = 0; i < 6; i++) begin
         logic [W-1:0] d, s, o, p;
         d = W'($urandom); s = W'($urandom); o = W'($urandom); p = W'($urandom);
         wr(A_DIR, d); wr(A_SEL, s); wr(A_DRV, o);
         periph_out = p;
         #1;
         check("R1 oe equals direction", pin_oe, d);
         check("R2 pin_out mux", pin_out, (s & p) | (~s & o));
         rd(A_DIR, r); check("R3 direction readback", r, d);
         rd(A_SEL, r); check("R3 select readback", r, s);
         rd(A_DRV, r); check("R3 output readback", r, o);
      end
      wr(A_DIR, '0);
      wr(A_SEL, '0);
      wr(A_DRV, '0);
      wr(A_IEN, 8'h3c); rd(A_IEN, r); check("R3 enable readback", r, 8'h3c);
      wr(A_POL, 8'h81); rd(A_POL, r); check("R3 polarity readback", r, 8'h81);
      wr(A_POL, '0);
      settle();
      wr(A_FLG, '0);

      // R4 level synchronisation, R3 level register ignores writes
      ext = 8'h5a;
      settle();
      rd(A_LVL, r); check("R4 level register", r, 8'h5a);
      check("R4 periph_in", periph_in, 8'h5a);
      wr(A_LVL, 8'hff);
      rd(A_LVL, r); check("R3 level write ignored", r, 8'h5a);
      ext = '0;
      settle();
      wr(A_FLG, '0);

      // R5 rising edge with polarity 0
      @(negedge clk); ext = 8'h01; settle();
      rd(A_FLG, r); check("R5 rising sets flag", r, 8'h01);
      wr(A_FLG, '0);
      @(negedge clk); ext = 8'h00; settle();
      rd(A_FLG, r); check("R5 falling ignored", r, 8'h00);

      // R6 falling edge with polarity 1
      wr(A_POL, 8'h02);
      @(negedge clk); ext = 8'h02; settle();
      rd(A_FLG, r); check("R10 polarity write sets flag", r, 8'h02);
      wr(A_FLG, '0);
      rd(A_FLG, r); check("R7 write 0 clears", r, 8'h00);
      @(negedge clk); ext = 8'h00; settle();
      rd(A_FLG, r); check("R6 falling sets flag", r, 8'h02);
      wr(A_FLG, '0);
      @(negedge clk); ext = 8'h02; settle();
      rd(A_FLG, r); check("R6 rising ignored", r, 8'h00);
      @(negedge clk); ext = 8'h00; settle();
      wr(A_POL, '0);
      settle();
      wr(A_FLG, 8'ha0);
      rd(A_FLG, r); check("R7 write 1 sets", r, 8'ha0);
      wr(A_FLG, '0);

      // R10 output write through loopback
      wr(A_DIR, 8'h80);
      settle();
      wr(A_FLG, '0);
      wr(A_DRV, 8'h80);
      settle();
      rd(A_FLG, r); check("R10 output write sets flag", r, 8'h80);
      wr(A_DRV, '0);
      wr(A_DIR, '0);
      settle();
      wr(A_FLG, '0);

      // R8 edge and clearing write land in the same cycle
      wr(A_FLG, 8'h02);
      @(negedge clk); ext = 8'h01;
      repeat (SYNC - 1) @(negedge clk);
      wr(A_FLG, 8'h00);
      rd(A_FLG, r); check("R8 edge beats clear", r, 8'h01);
      @(negedge clk); ext = 8'h00; settle();
      wr(A_FLG, '0);

      // R11 wake with the clock stopped
      gie = 1'b1;
      wr(A_IEN, 8'h10);
      @(negedge clk);
      clk_run = 1'b0;
      #40;
      check("R11 wake idle", wake, 0);
      ext = 8'h10;
      #5;
      check("R11 wake without clock", wake, 1);
      check("R9 irq before flag", irq, 0);
      #40;
      clk_run = 1'b1;
      settle();
      rd(A_FLG, r); check("R11 flag after restart", r, 8'h10);
      check("R9 irq flagged and enabled", irq, 1);
      gie = 1'b0;
      #1;
      check("R9 irq masked by gie", irq, 0);
      @(negedge clk); ext = 8'h00; settle();
      wr(A_FLG, '0);

      // Random mix of pin changes, polarity writes and flag writes
      ext = '0; pol_m = '0; flag_m = '0;
      for (int it = 0; it < 80; it++) begin
         int op;
         op = int'($urandom % 4);
         t_old = ext ^ pol_m;
         if (op < 2) begin
            @(negedge clk);
            ext = W'($urandom);
            flag_m |= new_edges(t_old, ext ^ pol_m);
            settle();
            rd(A_FLG, r); check("R5 R6 random edge flags", r, flag_m);
         end else if (op == 2) begin
            pol_m = W'($urandom);
            wr(A_POL, pol_m);
            flag_m |= new_edges(t_old, ext ^ pol_m);
            settle();
            rd(A_FLG, r); check("R10 random polarity flags", r, flag_m);
         end else begin
            flag_m = W'($urandom);
            wr(A_FLG, flag_m);
            rd(A_FLG, r); check("R7 random flag write", r, flag_m);
         end
         ien_m = W'($urandom);
         wr(A_IEN, ien_m);
         gie = 1'($urandom);
         #1;
         check("R9 random irq", irq, exp_irq(gie, flag_m, ien_m));
      end

      done = 1'b1;
      report();
      $finish;
   end

endmodule